// File: doc/BRIEF.md
# Reverse-Carry Pointer Update Unit

This block updates address pointers in one of two kinds of arithmetic. It holds a bank of eight 32-bit pointers. On each update it combines the selected pointer with a 32-bit offset and a 2-bit access-width code. A 4-bit mode input picks the arithmetic.

Linear mode is an ordinary binary add over the whole 32-bit space. Reverse-carry mode passes the carry from the most significant bit toward the least significant one. Before that add, the offset is scaled by the access width. This produces the bit-reversed index order used to step through the twiddle table of a 2^k-point FFT, or to reorder FFT output.

The update result for the selected pointer is available combinationally. It is written back into the bank on the clock edge where the update strobe is high. A separate read index presents any pointer of the bank.

Top module: `rcau_top`

## Requirements
- R1: While `rst_n` is low, every pointer of the bank is cleared to 0 at the next clock edge. With no update after that, `rd_ptr` reads 0 for every index.
- R2: With `mode` = 4'b0000, `upd_result` equals pointer + `offset` modulo 2^32. The offset is not scaled, no bits are cleared, and `width` has no effect.
- R3: With `mode` = 4'b0001, the add runs with the carry moving from bit 31 toward bit 0, and any carry out of bit 0 is dropped. Before any bit clearing, the sum equals bitrev(bitrev(pointer) + bitrev(scaled offset)).
- R4: In reverse-carry mode the offset is shifted left by 0, 1, 2 or 3 for `width` codes 00 (1 byte), 01 (2), 10 (4) and 11 (8). Bits shifted past bit 31 are discarded.
- R5: In reverse-carry mode, `upd_result` has its lowest 0, 1, 2 or 3 bits forced to zero for `width` codes 00, 01, 10 and 11 respectively.
- R6: Every `mode` value other than 4'b0001 gives linear arithmetic, exactly as in R2.
- R7: When `upd_en` is high at a rising clock edge, pointer `upd_idx` takes the value `upd_result` had before that edge. All other pointers keep their values.
- R8: When `upd_en` is low at a rising clock edge, no pointer changes.
- R9: `upd_result` is computed from pointer `upd_idx` in the same cycle. `rd_ptr` shows pointer `rd_idx` without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_en | input | 1 | Write the update result back into the bank |
| upd_idx | input | 3 | Index of the pointer being updated |
| mode | input | 4 | Arithmetic select: 0001 reverse-carry, any other code linear |
| width | input | 2 | Access-width code: 00=1, 01=2, 10=4, 11=8 bytes |
| offset | input | 32 | Offset added to the pointer |
| rd_idx | input | 3 | Index of the pointer shown on `rd_ptr` |
| upd_result | output | 32 | Updated value of pointer `upd_idx` |
| rd_ptr | output | 32 | Current value of pointer `rd_idx` |

## Verification
The hardest case to reach is a reverse-carry update whose carry ripples below the scaled offset's lowest set bit into the bits that width-based clearing must then remove. This needs a pointer with ones under the offset's position, and that can only be built up through earlier updates. The vector table therefore chains updates on one pointer: a bit-reversed walk first, then linear steps that plant low bits, then reverse-carry steps at widths 2 and 8 over them. It ends with an all-ones offset whose carry crosses nearly the whole word. A long random phase then compares every update against a bit-reverse/add/bit-reverse model, keeping a shadow copy of all eight pointers.

// File: rtl/rcau_pkg.sv
// Package: shared sizes and mode encodings for the pointer update unit.
// Assumes a 32-bit address space and a 2-bit access-width code.
package rcau_pkg;
    localparam int ADDR_W  = 32;
    localparam int NUM_PTR = 8;
    localparam int IDX_W   = $clog2(NUM_PTR);
    localparam int MODE_W  = 4;
    localparam int WID_W   = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_LINEAR = 4'b0000,
        MODE_REVC   = 4'b0001
    } rcau_mode_e;
endpackage

// File: rtl/rcau_revadd.sv
// Module: reverse-carry adder. Adds two vectors with the carry running
// from the most significant bit down toward bit 0; the carry out of bit 0
// is dropped. Purely combinational.
module rcau_revadd #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    // Ripple the carry downward, one bit pair at a time.
    always_comb begin
        logic cy;
        cy  = 1'b0;
        sum = '0;
        for (int i = W - 1; i >= 0; i--) begin
            sum[i] = a[i] ^ b[i] ^ cy;
            cy     = (a[i] & b[i]) | (a[i] & cy) | (b[i] & cy);
        end
    end
endmodule

// File: rtl/rcau_core.sv
// Module: combinational pointer update. Chooses linear or reverse-carry
// arithmetic from the mode code. In reverse-carry mode it scales the offset
// by the access width and clears the low result bits. Assumes the width
// code is 0..3, selecting a shift of the same amount.
module rcau_core
    import rcau_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int WW = WID_W
) (
    input  logic [AW-1:0]     ptr,
    input  logic [AW-1:0]     offset,
    input  logic [WW-1:0]     width,
    input  logic [MODE_W-1:0] mode,
    output logic [AW-1:0]     result
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] scaled_off;
    logic [AW-1:0] low_mask;
    logic [AW-1:0] rc_sum;
    logic [AW-1:0] lin_sum;

    // Scale the offset by the access size and build the low-bit mask.
    always_comb begin
        scaled_off = offset << width;
        low_mask   = (ONE << width) - ONE;
    end

    rcau_revadd #(.W(AW)) u_revadd (
        .a   (ptr),
        .b   (scaled_off),
        .sum (rc_sum)
    );

    // Plain binary add for linear mode.
    always_comb lin_sum = ptr + offset;

    // Pick the arithmetic; unlisted mode codes fall back to linear.
    always_comb begin
        if (mode == MODE_REVC) result = rc_sum & ~low_mask;
        else                   result = lin_sum;
    end
endmodule

// File: rtl/rcau_top.sv
// Module: pointer bank with reverse-carry/linear update. Holds NUM_PTR
// pointers, updates the one chosen by upd_idx through rcau_core, and writes
// the result back on a clock edge with upd_en high. Synchronous
// active-low reset clears every pointer.
module rcau_top
    import rcau_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [MODE_W-1:0] mode,
    input  logic [WID_W-1:0]  width,
    input  logic [ADDR_W-1:0] offset,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] upd_result,
    output logic [ADDR_W-1:0] rd_ptr
);
    logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0]              cur_ptr;

    // Select the pointer being updated and the one being read.
    always_comb begin
        cur_ptr = ptr_q[upd_idx];
        rd_ptr  = ptr_q[rd_idx];
    end

    rcau_core #(.AW(ADDR_W), .WW(WID_W)) u_core (
        .ptr    (cur_ptr),
        .offset (offset),
        .width  (width),
        .mode   (mode),
        .result (upd_result)
    );

    // One register per pointer; each loads only when addressed.
    for (genvar g = 0; g < NUM_PTR; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n)                               ptr_q[g] <= '0;
            else if (upd_en && upd_idx == IDX_W'(g))  ptr_q[g] <= upd_result;
        end
    end
endmodule

// File: rtl/rcau_top_chk.sv
// Module: assertion checker for rcau_top, bound to every instance.
// Observes the ports and the pointer bank.
module rcau_top_chk
    import rcau_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           upd_en,
    input  logic [IDX_W-1:0]               upd_idx,
    input  logic [MODE_W-1:0]              mode,
    input  logic [WID_W-1:0]               width,
    input  logic [ADDR_W-1:0]              offset,
    input  logic [ADDR_W-1:0]              upd_result,
    input  logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_q
);
    // R1
    rst_clear_chk: assert property (@(posedge clk) !rst_n |=> ptr_q == '0);

    // R2 R6
    lin_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 4'b0001) |-> upd_result == ptr_q[upd_idx] + offset);

    // R5
    low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'b0001) |-> ((upd_result & ((ADDR_W'(1) << width) - ADDR_W'(1))) == '0));

    // R7
    writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> ptr_q[$past(upd_idx)] == $past(upd_result));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !upd_en) |=> $stable(ptr_q));
endmodule

bind rcau_top rcau_top_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (upd_en),
    .upd_idx    (upd_idx),
    .mode       (mode),
    .width      (width),
    .offset     (offset),
    .upd_result (upd_result),
    .ptr_q      (ptr_q)
);

// File: tb/rcau_top_test.sv
`timescale 1ns/1ps
// Bench for rcau_top: a chained vector table on pointer 2, then directed
// and random checks against a bit-reverse/add/bit-reverse model.
module rcau_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic [2:0]  upd_idx = '0;
    logic [3:0]  mode = '0;
    logic [1:0]  width = '0;
    logic [31:0] offset = '0;
    logic [2:0]  rd_idx = '0;
    logic [31:0] upd_result;
    logic [31:0] rd_ptr;

    int checks = 0;
    int fails  = 0;
    logic [31:0] shadow [8];

    always #2.5 clk = ~clk;

    rcau_top uut (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_idx(upd_idx),
        .mode(mode), .width(width), .offset(offset), .rd_idx(rd_idx),
        .upd_result(upd_result), .rd_ptr(rd_ptr)
    );

    // Vector: {mode[3:0], width[1:0], offset[31:0], expected[31:0]}, all on pointer 2.
    localparam logic [69:0] VEC [12] = '{
        {4'h1, 2'd0, 32'h0000_0004, 32'h0000_0004},  // R3 bit-reversed walk
        {4'h1, 2'd0, 32'h0000_0004, 32'h0000_0002},
        {4'h1, 2'd0, 32'h0000_0004, 32'h0000_0006},
        {4'h1, 2'd0, 32'h0000_0004, 32'h0000_0001},
        {4'h0, 2'd3, 32'h0000_0010, 32'h0000_0011},  // R2 width ignored
        {4'h5, 2'd0, 32'hFFFF_FFFF, 32'h0000_0010},  // R6 wraps
        {4'h1, 2'd1, 32'h0000_0004, 32'h0000_0018},  // R4 scaled by 2
        {4'h1, 2'd1, 32'h0000_0004, 32'h0000_0014},
        {4'h1, 2'd3, 32'h0000_0001, 32'h0000_0018},  // R5 bit 2 cleared
        {4'h1, 2'd2, 32'h4000_0000, 32'h0000_0018},  // R4 shifted out
        {4'h1, 2'd0, 32'h8000_0000, 32'h8000_0018},
        {4'h1, 2'd0, 32'hFFFF_FFFF, 32'h0000_0018}   // R3 long carry
    };

    function automatic logic [31:0] bitrev(input logic [31:0] v);
        for (int i = 0; i < 32; i++) bitrev[i] = v[31 - i];
    endfunction

    function automatic logic [31:0] model(input logic [31:0] p, input logic [3:0] m,
                                          input logic [1:0] w, input logic [31:0] n);
        logic [31:0] s;
        if (m != 4'h1) return p + n;
        s = bitrev(bitrev(p) + bitrev(n << w));
        return s & ~((32'd1 << w) - 32'd1);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one update at a negedge, check the combinational result, clock it, read back.
    task automatic do_update(input string req, input logic [2:0] idx, input logic [3:0] m,
                             input logic [1:0] w, input logic [31:0] n, input logic [31:0] exp);
        @(negedge clk);
        upd_idx = idx; rd_idx = idx; mode = m; width = w; offset = n; upd_en = 1'b1;
        #1 check({req, " result"}, upd_result, exp);
        @(negedge clk);
        upd_en = 1'b0;
        #1 check({req, " R7 writeback"}, rd_ptr, exp);
    endtask

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state on every index; R9 read path
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i);
            #0.2 check("R1 reset", rd_ptr, 32'h0);
        end

        for (int v = 0; v < 12; v++)
            do_update("R3 table", 3'd2, VEC[v][69:66], VEC[v][65:64], VEC[v][63:32], VEC[v][31:0]);

        // R7 other pointers untouched
        for (int i = 0; i < 8; i++) begin
            if (i != 2) begin
                rd_idx = 3'(i);
                #0.2 check("R7 others", rd_ptr, 32'h0);
            end
        end

        // R8 strobe low: no change
        @(negedge clk);
        upd_idx = 3'd2; rd_idx = 3'd2; mode = 4'h1; offset = 32'h1234_5678; upd_en = 1'b0;
        repeat (2) @(negedge clk);
        #1 check("R8 hold", rd_ptr, 32'h0000_0018);

        // R3 R4 R5 random updates against the model
        for (int i = 0; i < 8; i++) shadow[i] = (i == 2) ? 32'h18 : 32'h0;
        for (int k = 0; k < 400; k++) begin
            logic [2:0]  ix;
            logic [3:0]  mm;
            logic [1:0]  ww;
            logic [31:0] nn;
            logic [31:0] ex;
            ix = 3'($urandom_range(0, 7));
            mm = ($urandom_range(0, 2) != 0) ? 4'h1 : 4'($urandom_range(0, 15));
            ww = 2'($urandom_range(0, 3));
            nn = $urandom();
            ex = model(shadow[ix], mm, ww, nn);
            do_update("R3 random", ix, mm, ww, nn, ex);
            shadow[ix] = ex;
        end

        // R1 reset after activity
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i);
            #0.2 check("R1 reset again", rd_ptr, 32'h0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule